// File: doc/BRIEF.md
# ALU with Stored Condition Flags and Branch Condition Evaluation

This block is a parameterised integer ALU (32 bits by default) with a small set of one-bit condition flags. The flags are updated as a side effect of each arithmetic, logic or shift operation. They are held in registers as architectural state. A conditional branch can therefore be decided from flags that an earlier operation left behind, with no compare in between.

The result is combinational from the operand and opcode inputs. The flags are captured on the rising clock edge when the flag-write enable is high and the opcode is legal. A compare performs a subtraction and updates the flags, but it marks its result as not to be written. The branch evaluator is combinational and reads only the stored flags. In the cycle that flags are being written, it still sees the values from before that write.

Top module: `alu_cc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `flags_o` reads all zero until the first flag write.
- R2: Opcodes 0 (add), 1 (subtract), 6 (increment) and 7 (decrement) produce `a+b`, `a-b`, `a+1` and `a-1` modulo 2^W. Carry (`flags_o[2]`) is the carry out for add and increment. It is the borrow (unsigned `a < b`, or `a == 0` for decrement) for subtract and decrement.
- R3: Opcodes 3 (and), 4 (or) and 5 (xor) give the bitwise result and clear carry and overflow. Opcodes 8 (shift left), 9 (logical right) and 10 (arithmetic right) shift `a` by `b[log2(W)-1:0]`. For these shifts, carry is the last bit shifted out (0 for a shift of zero) and overflow is cleared.
- R4: Sign (`flags_o[0]`) takes the most significant result bit. Zero (`flags_o[1]`) is 1 exactly when every result bit is 0.
- R5: Parity (`flags_o[3]`) is 1 when the low 8 result bits contain an even number of ones.
- R6: Overflow (`flags_o[4]`) is set on two's-complement overflow of add, subtract, compare, increment and decrement.
- R7: Flags change only on a rising edge where `flag_we_i` is high and the opcode is in 0..10. Opcodes 11..15 leave the flags unchanged and hold `result_we_o` low.
- R8: Opcode 2 (compare) sets all flags exactly as subtract does, and holds `result_we_o` low.
- R9: `taken_o` follows `cond_i` as follows: 0 gives zero, 1 gives not zero, 2 gives less-than (sign XOR overflow), and 3 gives greater-or-equal (the inverse of less-than). It depends on the stored flags only.
- R10: If a flag write and a branch evaluation fall in the same cycle, `taken_o` reflects the flags held before that write. The new flags decide from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand or shift amount |
| flag_we_i | input | 1 | Flag-write enable |
| cond_i | input | 2 | Branch condition select |
| result_o | output | W | Operation result |
| result_we_o | output | 1 | Result is meant to be written back |
| flags_o | output | 5 | Stored flags {overflow, parity, carry, zero, sign} |
| taken_o | output | 1 | Branch decision from stored flags |

## Verification
A flag update and a branch decision can coincide in one cycle. Every vector in the sweep drives an operation with a varying flag-write enable and a varying branch condition together, so both happen at once. The bench judges `taken_o` against its own model of the flags from the previous vector, before it applies the update. It then checks the new flags one cycle later. This separates a correct pre-update decision from one that wrongly bypasses the new flags.

// File: rtl/alu_cc_pkg.sv
`timescale 1ns/1ps
package alu_cc_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9,
    OP_SAR = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_NE = 2'd1,
    CC_LT = 2'd2,
    CC_GE = 2'd3
  } cc_sel_e;

  typedef struct packed {
    logic v;
    logic p;
    logic c;
    logic z;
    logic s;
  } flags_t;

  localparam int FLAG_BITS = $bits(flags_t);

  function automatic logic even_ones8(input logic [7:0] x);
    return ~^x;
  endfunction

  function automatic logic cc_decide(input flags_t f, input logic [1:0] sel);
    logic lt;
    lt = f.s ^ f.v;
    case (cc_sel_e'(sel))
      CC_EQ:   return f.z;
      CC_NE:   return ~f.z;
      CC_LT:   return lt;
      default: return ~lt;
    endcase
  endfunction

endpackage

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output flags_t       nf,
  output logic         res_we,
  output logic         op_ok
);
  localparam int SHW = $clog2(W);

  function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[W-1] ~^ y[W-1]) & (r[W-1] ^ x[W-1]);
  endfunction

  function automatic logic sub_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[W-1] ^ y[W-1]) & (r[W-1] ^ x[W-1]);
  endfunction

  logic [SHW-1:0]      amt;
  logic [W:0]          ext_add;
  logic [W:0]          ext_sub;
  logic [W:0]          ext_inc;
  logic [W:0]          ext_dec;
  logic [W:0]          ext_shl;
  logic [W:0]          ext_shr;
  logic signed [W:0]   ext_sar;
  logic [W-1:0]        one_w;
  logic                cy;
  logic                ov;

  assign one_w   = {{(W-1){1'b0}}, 1'b1};
  assign amt     = b[SHW-1:0];
  assign ext_add = {1'b0, a} + {1'b0, b};
  assign ext_sub = {1'b0, a} - {1'b0, b};
  assign ext_inc = {1'b0, a} + {1'b0, one_w};
  assign ext_dec = {1'b0, a} - {1'b0, one_w};
  assign ext_shl = {1'b0, a} << amt;
  assign ext_shr = {a, 1'b0} >> amt;
  assign ext_sar = $signed({a, 1'b0}) >>> amt;

  always_comb begin
    res    = '0;
    cy     = 1'b0;
    ov     = 1'b0;
    res_we = 1'b1;
    op_ok  = 1'b1;
    case (op)
      OP_ADD: begin
        {cy, res} = ext_add;
        ov = add_ovf(a, b, ext_add[W-1:0]);
      end
      OP_SUB, OP_CMP: begin
        {cy, res} = ext_sub;
        ov = sub_ovf(a, b, ext_sub[W-1:0]);
        res_we = (op != OP_CMP);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_INC: begin
        {cy, res} = ext_inc;
        ov = add_ovf(a, one_w, ext_inc[W-1:0]);
      end
      OP_DEC: begin
        {cy, res} = ext_dec;
        ov = sub_ovf(a, one_w, ext_dec[W-1:0]);
      end
      OP_SHL: {cy, res} = ext_shl;
      OP_SHR: {res, cy} = ext_shr;
      OP_SAR: {res, cy} = ext_sar;
      default: begin
        op_ok  = 1'b0;
        res_we = 1'b0;
      end
    endcase
  end

  always_comb begin
    nf.s = res[W-1];
    nf.z = ~|res;
    nf.p = even_ones8(res[7:0]);
    nf.c = cy;
    nf.v = ov;
  end

endmodule

// File: rtl/flag_store.sv
`timescale 1ns/1ps
module flag_store
  import alu_cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t nxt,
  output flags_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= '0;
    else if (upd) cur <= nxt;
  end
endmodule

// File: rtl/cc_eval.sv
`timescale 1ns/1ps
module cc_eval
  import alu_cc_pkg::*;
(
  input  flags_t     f,
  input  logic [1:0] sel,
  output logic       taken
);
  assign taken = cc_decide(f, sel);
endmodule

// File: rtl/alu_cc_unit.sv
`timescale 1ns/1ps
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flag_we_i,
  input  logic [1:0]   cond_i,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic [4:0]   flags_o,
  output logic         taken_o
);
  flags_t next_flags;
  flags_t held_flags;
  logic   op_ok;
  logic   flag_upd;

  alu_datapath #(.W(W)) u_dp (
    .op     (op_i),
    .a      (a_i),
    .b      (b_i),
    .res    (result_o),
    .nf     (next_flags),
    .res_we (result_we_o),
    .op_ok  (op_ok)
  );

  assign flag_upd = flag_we_i & op_ok;

  flag_store u_fs (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (flag_upd),
    .nxt   (next_flags),
    .cur   (held_flags)
  );

  cc_eval u_ce (
    .f     (held_flags),
    .sel   (cond_i),
    .taken (taken_o)
  );

  assign flags_o = held_flags;

endmodule

// File: rtl/alu_cc_checker.sv
`timescale 1ns/1ps
module alu_cc_checker
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   cond_i,
  input logic [W-1:0] result_o,
  input logic         result_we_o,
  input logic [4:0]   flags_o,
  input logic         taken_o,
  input logic         op_ok,
  input logic         flag_upd
);
  logic is_logic;
  assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> flags_o == $past(flags_o)); // R7
  AST_BAD_OP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ok |-> !result_we_o); // R7
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_CMP |-> !result_we_o); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> flags_o[1] == ($past(result_o) == '0)); // R4
  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> flags_o[0] == $past(result_o[W-1])); // R4
  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> flags_o[3] == ($countones($past(result_o[7:0])) % 2 == 0)); // R5
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd && is_logic |=> !flags_o[2] && !flags_o[4]); // R3
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd && op_i == OP_ADD |=> flags_o[2] == ($past(result_o) < $past(a_i))); // R2
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd && (op_i == OP_SUB || op_i == OP_CMP) |=> flags_o[2] == ($past(a_i) < $past(b_i))); // R2
  AST_TAKEN_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 2'd0 |-> taken_o == flags_o[1]); // R9
  AST_TAKEN_NE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 2'd1 |-> taken_o != flags_o[1]); // R9
  AST_TAKEN_LT: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 2'd2 |-> taken_o == (flags_o[0] != flags_o[4])); // R9
  AST_TAKEN_GE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 2'd3 |-> taken_o == (flags_o[0] == flags_o[4])); // R9
endmodule

bind alu_cc_unit alu_cc_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .cond_i      (cond_i),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .flags_o     (flags_o),
  .taken_o     (taken_o),
  .op_ok       (op_ok),
  .flag_upd    (flag_upd)
);

// File: tb/sim_alu_cc_unit.sv
`timescale 1ns/1ps
module sim_alu_cc_unit;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    op_i = '0;
  logic [BW-1:0] a_i = '0;
  logic [BW-1:0] b_i = '0;
  logic          flag_we_i = 1'b0;
  logic [1:0]    cond_i = '0;
  logic [BW-1:0] result_o;
  logic          result_we_o;
  logic [4:0]    flags_o;
  logic          taken_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_cc_unit #(.W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_we_i(flag_we_i), .cond_i(cond_i), .result_o(result_o),
    .result_we_o(result_we_o), .flags_o(flags_o), .taken_o(taken_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Model: returns result, flags {v,p,c,z,s}, legality and write-back
  function automatic void model(input int op, input int a, input int b,
                                output int res, output bit [4:0] fl,
                                output bit legal, output bit wr);
    int sa, sb, sr, k, ones;
    bit c, v;
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    k = b % 8;
    c = 0; v = 0; legal = 1; wr = 1; res = 0;
    case (op)
      0:    begin res = (a + b) % 256; c = (a + b) > 255; sr = sa + sb; v = (sr > 127) || (sr < -128); end
      1, 2: begin res = (a - b + 256) % 256; c = a < b; sr = sa - sb; v = (sr > 127) || (sr < -128); wr = (op == 1); end
      3:    res = a & b;
      4:    res = a | b;
      5:    res = a ^ b;
      6:    begin res = (a + 1) % 256; c = (a == 255); v = (a == 127); end
      7:    begin res = (a + 255) % 256; c = (a == 0); v = (a == 128); end
      8:    begin res = (a << k) & 255; c = (k > 0) ? ((a >> (8 - k)) & 1) : 0; end
      9:    begin res = a >> k; c = (k > 0) ? ((a >> (k - 1)) & 1) : 0; end
      10:   begin res = (sa >>> k) & 255; c = (k > 0) ? ((a >> (k - 1)) & 1) : 0; end
      default: begin legal = 0; wr = 0; end
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
    fl = {v, (ones % 2) == 0, c, res == 0, res[7]};
  endfunction

  function automatic bit decide(input bit [4:0] fl, input int cs);
    case (cs)
      0: return fl[1];
      1: return !fl[1];
      2: return fl[0] ^ fl[4];
      default: return !(fl[0] ^ fl[4]);
    endcase
  endfunction

  function automatic string carry_tag(input int op);
    if (op == 2) return "R8";
    if (op >= 3 && op <= 5) return "R3";
    if (op >= 8) return "R3";
    return "R2";
  endfunction

  function automatic int pick_b(input int i, input int a);
    case (i)
      0: return 0;   1: return 1;   2: return 2;   3: return 3;
      4: return 5;   5: return 7;   6: return 8;   7: return 15;
      8: return 16;  9: return 127; 10: return 128; 11: return 129;
      12: return 170; 13: return 254; 14: return 255;
      default: return a;
    endcase
  endfunction

  task automatic check_flags(input bit [4:0] mf, input int prev_op, input bit wrote);
    string ctag;
    ctag = wrote ? carry_tag(prev_op) : "R7";
    chk(flags_o[0] == mf[0], wrote ? "R4" : "R7", "sign", flags_o[0], mf[0]);
    chk(flags_o[1] == mf[1], wrote ? "R4" : "R7", "zero", flags_o[1], mf[1]);
    chk(flags_o[2] == mf[2], ctag, "carry", flags_o[2], mf[2]);
    chk(flags_o[3] == mf[3], wrote ? "R5" : "R7", "parity", flags_o[3], mf[3]);
    chk(flags_o[4] == mf[4], wrote ? "R6" : "R7", "overflow", flags_o[4], mf[4]);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [4:0] mf;
    bit [4:0] nfl;
    bit legal, wr, wrote;
    int res, prev_op;
    mf = '0; wrote = 0; prev_op = 0;
    repeat (3) @(negedge clk);
    // R1: flags clear during reset
    chk(flags_o == 5'd0, "R1", "flags in reset", flags_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flags_o == 5'd0, "R1", "flags after reset", flags_o, 0);
    cond_i = 2'd1; #1;
    chk(taken_o == 1'b1, "R9", "NE after reset", taken_o, 1);
    cond_i = 2'd0; #1;
    chk(taken_o == 1'b0, "R9", "EQ after reset", taken_o, 0);
    @(negedge clk);

    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          int b;
          bit we;
          int cs;
          b  = pick_b(bi, a);
          we = ((a + bi) % 7) != 0;
          cs = (a + bi + op) % 4;
          check_flags(mf, prev_op, wrote);
          op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0];
          flag_we_i = we; cond_i = cs[1:0];
          #1;
          model(op, a, b, res, nfl, legal, wr);
          chk(result_we_o == wr, legal ? (op == 2 ? "R8" : "R2") : "R7", "result_we",
              result_we_o, wr);
          if (legal)
            chk(result_o == res[7:0], carry_tag(op), "result", result_o, res);
          // R10: decision uses flags before this cycle's write; R9 encoding
          chk(taken_o == decide(mf, cs), we && legal ? "R10" : "R9", "taken",
              taken_o, decide(mf, cs));
          wrote = we && legal;
          if (wrote) mf = nfl;
          prev_op = op;
          @(negedge clk);
        end
      end
    end
    check_flags(mf, prev_op, wrote);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule